// File: doc/BRIEF.md
# RV32I Integer ALU with Barrel Shifter

This block is the purely combinational arithmetic logic unit for the integer register and immediate operations of a 32-bit RISC-V core. It takes two 32-bit operands and a 4-bit operation code. It returns a 32-bit result and a flag that marks signed overflow. There is no clock and no state: the result follows the inputs within the same cycle, so the surrounding execute stage registers it.

Addition and subtraction share one adder. For subtraction the adder inverts the second operand and adds a carry-in of one. Both comparisons are taken from that same subtraction. The signed comparison uses the sign of the difference corrected by overflow. The unsigned comparison uses the missing carry-out. Shifts pass through a network of five stages, and each stage moves the data by a power of two. A left shift reverses the bits, shifts right, and reverses them back. The overflow flag is for information only: it never changes the result, and it never raises a trap.

Top module: `rv32i_alu`

## Requirements
- R1: With op code 0 (add), `result_o` equals `(operand_a_i + operand_b_i) mod 2^32`.
- R2: With op code 1 (subtract), `result_o` equals `(operand_a_i - operand_b_i) mod 2^32`.
- R3: With op code 0 or 1, `overflow_o` is 1 exactly when the true signed sum or difference lies outside [-2^31, 2^31-1]. With every other op code `overflow_o` is 0. The flag never changes `result_o`.
- R4: Op code 9 returns the bitwise AND of the two operands, op code 8 the bitwise OR, and op code 5 the bitwise XOR.
- R5: Op code 2 shifts `operand_a_i` left by the shift amount and fills the vacated low bits with 0.
- R6: Op code 6 shifts `operand_a_i` right by the shift amount and fills the vacated high bits with 0.
- R7: Op code 7 shifts `operand_a_i` right by the shift amount and fills the vacated high bits with `operand_a_i[31]`.
- R8: The shift amount is `operand_b_i[4:0]` (0 to 31). Bits `operand_b_i[31:5]` have no effect on a shift result.
- R9: Op code 3 returns 1 in bit 0 when `operand_a_i < operand_b_i` as signed two's-complement values, and 0 otherwise. Bits 31:1 are always 0.
- R10: Op code 4 returns 1 in bit 0 when `operand_a_i < operand_b_i` as unsigned values, and 0 otherwise. Bits 31:1 are always 0.
- R11: Op codes 10 to 15 return `result_o` = 0 and `overflow_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_a_i | input | 32 | First operand; the value that is shifted |
| operand_b_i | input | 32 | Second operand; bits 4:0 give the shift amount |
| op_sel_i | input | 4 | Operation code |
| result_o | output | 32 | Operation result |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench sweeps every op code across a set of corner operands: zero, one, all ones, the most positive and most negative values, and mixed bit patterns. Each result is compared with arithmetic done in 64-bit integers.

The bench targets several faults, each with a visible symptom:
- **Overflow flag:** an adder that mixes up carry-out and signed overflow, or a subtract that fails to invert the operand, gives a wrong flag at the most positive and most negative values.
- **Signed compare:** a compare that skips the overflow correction gets 0x80000000 versus positive values wrong.
- **Shift amounts and fill:** every amount from 0 to 31 is applied, with clean upper operand bits and with junk in them. A stage wired to the wrong amount bit shows up, as does a right shift that fills with the wrong bit or a shifter that reads bits above 4.
- **Unused codes:** these must come back as zero.

// File: rtl/rv32i_alu_pkg.sv
package rv32i_alu_pkg;
  localparam int XLEN    = 32;
  localparam int SHAMT_W = $clog2(XLEN);

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_SLL  = 4'd2,
    ALU_SLT  = 4'd3,
    ALU_SLTU = 4'd4,
    ALU_XOR  = 4'd5,
    ALU_SRL  = 4'd6,
    ALU_SRA  = 4'd7,
    ALU_OR   = 4'd8,
    ALU_AND  = 4'd9
  } alu_op_e;
endpackage

// File: rtl/rv32i_alu_addsub.sv
module rv32i_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff   = sub_i ? ~b_i : b_i;
  assign full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  // operands of equal sign yielding a result of the other sign
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/rv32i_alu_logic.sv
module rv32i_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] xor_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
    assign xor_o[i] = a_i[i] ^ b_i[i];
  end
endmodule

// File: rtl/rv32i_alu_shifter.sv
module rv32i_alu_shifter #(
  parameter int W       = 32,
  parameter int SHAMT_W = $clog2(W)
) (
  input  logic [W-1:0]       data_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic               left_i,
  input  logic               arith_i,
  output logic [W-1:0]       data_o
);
  logic [W-1:0] stage [SHAMT_W+1];
  logic [W-1:0] rev_in;
  logic [W-1:0] rev_out;
  logic         fill;

  // left shift = reverse, shift right, reverse
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = stage[SHAMT_W][W-1-i];
  end

  assign fill     = arith_i & ~left_i & data_i[W-1];
  assign stage[0] = left_i ? rev_in : data_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = shamt_i[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  assign data_o = left_i ? rev_out : stage[SHAMT_W];
endmodule

// File: rtl/rv32i_alu.sv
module rv32i_alu
  import rv32i_alu_pkg::*;
(
  input  logic [31:0] operand_a_i,
  input  logic [31:0] operand_b_i,
  input  logic [3:0]  op_sel_i,
  output logic [31:0] result_o,
  output logic        overflow_o
);
  logic [XLEN-1:0] sum, and_v, or_v, xor_v, shift_v;
  logic            carry, ovf, sub_en, arith_op, lt_s, lt_u;

  assign sub_en   = (op_sel_i == ALU_SUB) || (op_sel_i == ALU_SLT) || (op_sel_i == ALU_SLTU);
  assign arith_op = (op_sel_i == ALU_ADD) || (op_sel_i == ALU_SUB);

  rv32i_alu_addsub #(.W(XLEN)) u_addsub (
    .a_i     (operand_a_i),
    .b_i     (operand_b_i),
    .sub_i   (sub_en),
    .sum_o   (sum),
    .carry_o (carry),
    .ovf_o   (ovf)
  );

  rv32i_alu_logic #(.W(XLEN)) u_logic (
    .a_i   (operand_a_i),
    .b_i   (operand_b_i),
    .and_o (and_v),
    .or_o  (or_v),
    .xor_o (xor_v)
  );

  rv32i_alu_shifter #(.W(XLEN), .SHAMT_W(SHAMT_W)) u_shifter (
    .data_i  (operand_a_i),
    .shamt_i (operand_b_i[SHAMT_W-1:0]),
    .left_i  (op_sel_i == ALU_SLL),
    .arith_i (op_sel_i == ALU_SRA),
    .data_o  (shift_v)
  );

  assign lt_s = sum[XLEN-1] ^ ovf;
  assign lt_u = ~carry;

  always_comb begin
    case (op_sel_i)
      ALU_ADD, ALU_SUB: result_o = sum;
      ALU_SLL, ALU_SRL, ALU_SRA: result_o = shift_v;
      ALU_SLT:  result_o = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU: result_o = {{(XLEN-1){1'b0}}, lt_u};
      ALU_XOR:  result_o = xor_v;
      ALU_OR:   result_o = or_v;
      ALU_AND:  result_o = and_v;
      default:  result_o = '0;
    endcase
  end

  assign overflow_o = arith_op & ovf;
endmodule

// File: rtl/rv32i_alu_chk.sv
module rv32i_alu_chk (
  input logic [31:0] operand_a_i,
  input logic [31:0] operand_b_i,
  input logic [3:0]  op_sel_i,
  input logic [31:0] result_o,
  input logic        overflow_o
);
  always_comb begin
    // R3
    if (op_sel_i > 4'd1) ovf_scope_chk: assert (!overflow_o);
    // R2
    if (op_sel_i == 4'd1 && operand_a_i == operand_b_i)
      sub_self_chk: assert (result_o == 32'd0 && !overflow_o);
    // R5
    if (op_sel_i == 4'd2 && operand_b_i[4:0] == 5'd0)
      sll_zero_amt_chk: assert (result_o == operand_a_i);
    // R7
    if (op_sel_i == 4'd7) sra_sign_chk: assert (result_o[31] == operand_a_i[31]);
    // R9
    if (op_sel_i == 4'd3) slt_ext_chk: assert (result_o[31:1] == 31'd0);
    // R10
    if (op_sel_i == 4'd4) sltu_ext_chk: assert (result_o[31:1] == 31'd0);
    // R11
    if (op_sel_i > 4'd9) unused_zero_chk: assert (result_o == 32'd0 && !overflow_o);
  end
endmodule

bind rv32i_alu rv32i_alu_chk u_chk (
  .operand_a_i (operand_a_i),
  .operand_b_i (operand_b_i),
  .op_sel_i    (op_sel_i),
  .result_o    (result_o),
  .overflow_o  (overflow_o)
);

// File: tb/rv32i_alu_bench.sv
module rv32i_alu_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op;
  logic [31:0] res;
  logic        ovf;
  int          n_run = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  rv32i_alu u_rv32i_alu (
    .operand_a_i (a),
    .operand_b_i (b),
    .op_sel_i    (op),
    .result_o    (res),
    .overflow_o  (ovf)
  );

  logic [31:0] vals [10] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
                             32'h1234_5678, 32'hDEAD_BEEF, 32'h8000_0001, 32'h0000_0020,
                             32'h7FFF_FFFE};

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R5";
      4'd3: return "R9";  4'd4: return "R10"; 4'd5: return "R4";
      4'd6: return "R6";  4'd7: return "R7";  4'd8: return "R4";
      4'd9: return "R4";  default: return "R11";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       output logic [31:0] r, output logic v);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint ux = longint'({32'd0, x});
    longint uy = longint'({32'd0, y});
    longint pw = longint'(64'd1 << y[4:0]);
    longint t;
    r = 32'd0; v = 1'b0;
    case (o)
      4'd0: begin t = sx + sy; r = t[31:0]; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd1: begin t = sx - sy; r = t[31:0]; v = (t > 64'sd2147483647) || (t < -64'sd2147483648); end
      4'd2: begin t = ux * pw; r = t[31:0]; end
      4'd3: r = {31'd0, sx < sy};
      4'd4: r = {31'd0, ux < uy};
      4'd5: r = x ^ y;
      4'd6: begin t = ux / pw; r = t[31:0]; end
      4'd7: begin
        if (x[31]) begin t = longint'({32'd0, ~x}) / pw; r = ~t[31:0]; end
        else begin t = ux / pw; r = t[31:0]; end
      end
      4'd8: r = x | y;
      4'd9: r = x & y;
      default: ;
    endcase
  endtask

  task automatic run_one(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input string tag);
    logic [31:0] er;
    logic        ev;
    model(o, x, y, er, ev);
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    n_run++;
    if (res !== er) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h result=%h expected=%h", tag, o, x, y, res, er);
    end
    n_run++;
    if (ovf !== ev) begin
      n_fail++;
      $display("FAIL R3 op=%0d a=%h b=%h overflow=%b expected=%b", o, x, y, ovf, ev);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; op = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset / idle state: zero operands add to zero (R1)
    @(negedge clk);
    n_run++;
    if (res !== 32'd0 || ovf !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle result=%h expected=0", res);
    end
    // all op codes across corner operands (R1 R2 R3 R4 R9 R10 R11)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_one(4'(o), vals[i], vals[j], req_of(4'(o)));
    // every shift amount, clean and with junk above bit 4 (R5 R6 R7 R8)
    for (int i = 0; i < 10; i++)
      for (int s = 0; s < 32; s++) begin
        run_one(4'd2, vals[i], 32'(s), "R5");
        run_one(4'd6, vals[i], 32'(s), "R6");
        run_one(4'd7, vals[i], 32'(s), "R7");
        run_one(4'd2, vals[i], 32'hA5A5_A5A0 | 32'(s), "R8");
        run_one(4'd6, vals[i], 32'hFFFF_FFE0 | 32'(s), "R8");
        run_one(4'd7, vals[i], 32'h5A5A_5A40 | 32'(s), "R8");
      end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule